// File: doc/BRIEF.md
# Slope-Compensation Ramp Generator with Trip Latch

This block produces a falling reference word for a comparator in a peak-current-mode control loop. The reference is a register that is loaded with a programmed start value. While the ramp runs, the register drops by a programmed step on every clock and stops at zero. A single-cycle sync pulse from the PWM timer reloads the start value and sets the ramp running. The timer derives this pulse from its "counter equals compare C while counting up" event, not from the compare that moves the PWM output edge.

A comparator trip also reloads the start value, but it leaves the ramp held. The ramp then waits at the start value until the next sync pulse. A trip latch remembers that a trip occurred, and the sync pulse clears it. The trip can be taken straight from the comparator status or through a majority-vote filter. The filter has a programmable window and threshold. The sync pulse does not flush the filter's history, so a trip that is still present in that history sets the latch again on the next clock.

The comparator is represented digitally: its status is high while the input code is greater than the current reference word.

Top module: `slope_ramp_cmp`

## Requirements
- R1: While `rst_n` is low and after it rises, `dac_word` equals `start_val` at the last reset edge, the ramp is held (it does not decrement without a sync pulse), and `trip_latched` is 0.
- R2: A clock edge with `sync_pulse` high loads `dac_word` with `start_val`. After that, `dac_word` drops by `step_val` on each clock edge while no trip or sync pulse occurs.
- R3: A running ramp whose word is not greater than `step_val` goes to 0 and stays at 0. It never wraps.
- R4: A trip at a clock edge without a sync pulse loads `dac_word` with `start_val` and holds it there until the next sync pulse.
- R5: When a sync pulse and a trip occur at the same edge, the sync pulse has priority and the ramp starts decrementing from `start_val`.
- R6: `cmp_status` is 1 exactly when `cmp_code > dac_word`, evaluated combinationally in the same cycle.
- R7: `trip_latched` becomes 1 at the edge after a trip. It stays 1 until an edge with `sync_pulse` high, which clears it. The clear has priority over a trip at that same edge.
- R8: A sync pulse leaves the filter history unchanged. If the filtered trip is still asserted, `trip_latched` is 1 again one edge after the clear.
- R9: With `filt_en` = 0, the trip at each edge is `cmp_status` itself.
- R10: With `filt_en` = 1, the trip at an edge is 1 when at least `filt_thr` of the last `min(filt_win, FILT_LEN)` values of `cmp_status`, sampled at the preceding edges, were 1. The filter history is cleared by reset, and `filt_thr` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_val | input | DAC_W | Ramp start value |
| step_val | input | DAC_W | Decrement per clock while running |
| sync_pulse | input | 1 | Single-cycle PWM sync (reload and run) |
| cmp_code | input | DAC_W | Input code compared against the ramp |
| filt_en | input | 1 | 1 selects the majority filter for the trip |
| filt_win | input | WIN_W | Filter window length, clamped to FILT_LEN |
| filt_thr | input | WIN_W | Ones needed in the window to trip |
| dac_word | output | DAC_W | Current ramp reference word |
| cmp_status | output | 1 | Raw comparator status |
| trip_latched | output | 1 | Trip latch output |

## Verification
On every cycle the assertions check the ramp transitions: reload and run on a sync pulse, reload and hold on a lone trip, no increase while running, and a frozen word while held. They also check that the latch sets, holds and clears as specified, and that the filter cannot trip when its threshold is beyond its window or its history is empty. Only the bench scenarios can show that specific values come out correctly. These are the exact saturation at zero, the sync-over-trip priority seen through the word two cycles later, the latch setting again one cycle after a sync clear while the unflushed filter is still asserted, and the window-and-threshold vote across random settings.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_RUN  = 2'd1,
    ACT_SYNC = 2'd2,
    ACT_TRIP = 2'd3
  } ramp_act_e;

  // Priority: sync pulse first, then trip, then continue the current state.
  function automatic ramp_act_e pick_action(input logic sync, input logic trip,
                                            input logic run);
    if (sync)      return ACT_SYNC;
    else if (trip) return ACT_TRIP;
    else if (run)  return ACT_RUN;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/ramp_core.sv
module ramp_core #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DAC_W-1:0] start_val,
  input  logic [DAC_W-1:0] step_val,
  input  logic             ev_sync,
  input  logic             ev_trip,
  output logic [DAC_W-1:0] dac_q,
  output logic             run_q
);
  import ramp_pkg::*;

  function automatic logic [DAC_W-1:0] sat_sub(input logic [DAC_W-1:0] a,
                                               input logic [DAC_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  ramp_act_e act;
  assign act = pick_action(ev_sync, ev_trip, run_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q <= start_val;
      run_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_SYNC: begin dac_q <= start_val; run_q <= 1'b1; end
        ACT_TRIP: begin dac_q <= start_val; run_q <= 1'b0; end
        ACT_RUN:  dac_q <= sat_sub(dac_q, step_val);
        ACT_HOLD: dac_q <= dac_q;
      endcase
    end
  end

  // R2
  sync_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> (dac_q == $past(start_val)) && run_q);

  // R4
  trip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trip && !ev_sync) |=> (dac_q == $past(start_val)) && !run_q);

  // R3
  run_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ev_sync && !ev_trip) |=> (dac_q <= $past(dac_q)) && run_q);

  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ev_sync && !ev_trip) |=> $stable(dac_q) && !run_q);

endmodule

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int FILT_LEN = 8,
  parameter int WIN_W    = $clog2(FILT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [WIN_W-1:0] win,
  input  logic [WIN_W-1:0] thr,
  output logic             filt_trip
);
  logic [FILT_LEN-1:0] hist;

  function automatic logic vote(input logic [FILT_LEN-1:0] h,
                                input logic [WIN_W-1:0] w,
                                input logic [WIN_W-1:0] t);
    logic [WIN_W-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < FILT_LEN; i++) begin
      if (i < int'(w)) cnt = cnt + WIN_W'(h[i]);
    end
    return cnt >= t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= (hist << 1) | FILT_LEN'(raw);
  end

  assign filt_trip = vote(hist, win, thr);

  // R10
  vote_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_trip |-> (int'(thr) <= ((int'(win) > FILT_LEN) ? FILT_LEN : int'(win))));

  // R10
  empty_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr != '0) && (hist == '0)) |-> !filt_trip);

endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_sync,
  input  logic ev_trip,
  output logic latch_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= 1'b0;
    else if (ev_sync) latch_q <= 1'b0;
    else if (ev_trip) latch_q <= 1'b1;
  end

  // R7
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trip && !ev_sync) |=> latch_q);

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> !latch_q);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !ev_sync) |=> latch_q);

endmodule

// File: rtl/slope_ramp_cmp.sv
module slope_ramp_cmp #(
  parameter  int DAC_W    = 12,
  parameter  int FILT_LEN = 8,
  localparam int WIN_W    = $clog2(FILT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DAC_W-1:0] start_val,
  input  logic [DAC_W-1:0] step_val,
  input  logic             sync_pulse,
  input  logic [DAC_W-1:0] cmp_code,
  input  logic             filt_en,
  input  logic [WIN_W-1:0] filt_win,
  input  logic [WIN_W-1:0] filt_thr,
  output logic [DAC_W-1:0] dac_word,
  output logic             cmp_status,
  output logic             trip_latched
);
  logic ev_sync;
  logic ev_trip;
  logic filt_trip;
  logic run_q;

  assign ev_sync    = sync_pulse;
  assign cmp_status = cmp_code > dac_word;
  assign ev_trip    = filt_en ? filt_trip : cmp_status;

  ramp_core #(.DAC_W(DAC_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start_val(start_val), .step_val(step_val),
    .ev_sync(ev_sync), .ev_trip(ev_trip), .dac_q(dac_word), .run_q(run_q)
  );

  trip_filter #(.FILT_LEN(FILT_LEN), .WIN_W(WIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(cmp_status), .win(filt_win),
    .thr(filt_thr), .filt_trip(filt_trip)
  );

  trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ev_sync(ev_sync), .ev_trip(ev_trip),
    .latch_q(trip_latched)
  );

  // R5
  sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sync && ev_trip) |=> run_q && !trip_latched);

endmodule

// File: tb/slope_ramp_cmp_test.sv
module slope_ramp_cmp_test;
  localparam int DW  = 12;
  localparam int LEN = 8;
  localparam int WW  = $clog2(LEN + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] start_val, step_val, cmp_code;
  logic          sync_pulse, filt_en;
  logic [WW-1:0] filt_win, filt_thr;
  logic [DW-1:0] dac_word;
  logic          cmp_status, trip_latched;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  logic [DW-1:0]  m_dac;
  logic           m_run, m_latch;
  logic [LEN-1:0] m_hist;

  always #5 clk = ~clk;

  slope_ramp_cmp #(.DAC_W(DW), .FILT_LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .start_val(start_val), .step_val(step_val),
    .sync_pulse(sync_pulse), .cmp_code(cmp_code), .filt_en(filt_en),
    .filt_win(filt_win), .filt_thr(filt_thr), .dac_word(dac_word),
    .cmp_status(cmp_status), .trip_latched(trip_latched)
  );

  function automatic logic bench_vote(input logic [LEN-1:0] h, input int w, input int t);
    int lim, ones;
    lim = (w > LEN) ? LEN : w;
    ones = 0;
    for (int k = 0; k < lim; k++) ones += int'(h[k]);
    return ones >= t;
  endfunction

  task automatic check(input string t, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(tag, "dac_word", int'(dac_word), int'(m_dac));
    check("R6", "cmp_status", int'(cmp_status), int'(cmp_code > m_dac));
    check((tag == "R8") ? "R8" : "R7", "trip_latched", int'(trip_latched), int'(m_latch));
  endtask

  // Advance one clock: model computes its next state from the current inputs.
  task automatic step(input logic s);
    logic raw, trp;
    sync_pulse = s;
    raw = cmp_code > m_dac;
    trp = filt_en ? bench_vote(m_hist, int'(filt_win), int'(filt_thr)) : raw;
    if (s) begin
      m_dac = start_val; m_run = 1'b1; m_latch = 1'b0;
    end else if (trp) begin
      m_dac = start_val; m_run = 1'b0; m_latch = 1'b1;
    end else if (m_run) begin
      m_dac = (m_dac > step_val) ? m_dac - step_val : '0;
    end
    m_hist = {m_hist[LEN-2:0], raw};
    @(posedge clk);
    @(negedge clk);
    sync_pulse = 1'b0;
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sync_pulse = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_dac = start_val; m_run = 1'b0; m_latch = 1'b0; m_hist = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4021));
    start_val = 12'd1000; step_val = 12'd7; cmp_code = '0;
    filt_en = 1'b0; filt_win = WW'(4); filt_thr = WW'(2);

    // R1: reset state and hold without sync
    tag = "R1";
    do_reset();
    check("R1", "reset dac_word", int'(dac_word), 1000);
    check("R1", "reset trip_latched", int'(trip_latched), 0);
    repeat (5) step(1'b0);
    check("R1", "held after reset", int'(dac_word), 1000);

    // R2: sync starts decrement by step
    tag = "R2";
    step(1'b1);
    check("R2", "dac after sync", int'(dac_word), 1000);
    step(1'b0);
    check("R2", "dac one step", int'(dac_word), 993);
    repeat (10) step(1'b0);

    // R3: saturation at zero
    tag = "R3";
    step_val = 12'd300;
    step(1'b1);
    repeat (6) step(1'b0);
    check("R3", "saturated", int'(dac_word), 0);

    // R4 and R7: trip reloads and holds, latch sets
    tag = "R4";
    step_val = 12'd50; cmp_code = 12'd500;
    step(1'b1);
    repeat (20) step(1'b0);
    check("R4", "held at start", int'(dac_word), 1000);
    check("R7", "latched", int'(trip_latched), 1);
    tag = "R7";
    step(1'b1);
    check("R7", "sync clears", int'(trip_latched), 0);
    repeat (15) step(1'b0);

    // R5: sync and trip at the same edge
    tag = "R5";
    step_val = 12'd100; cmp_code = 12'd750;
    step(1'b1);
    repeat (3) step(1'b0);
    check("R5", "at trip point", int'(dac_word), 700);
    step(1'b1);
    step(1'b0);
    check("R5", "decrement started", int'(dac_word), 900);

    // R8: filter not flushed by sync
    tag = "R8";
    filt_en = 1'b1; filt_win = WW'(4); filt_thr = WW'(2); cmp_code = 12'd2000;
    repeat (6) step(1'b0);
    step(1'b1);
    check("R8", "cleared by sync", int'(trip_latched), 0);
    step(1'b0);
    check("R8", "set again at once", int'(trip_latched), 1);

    // R9: random, filter off
    tag = "R9";
    filt_en = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) begin
        start_val = DW'(200 + $urandom_range(0, 3800));
        step_val  = DW'($urandom_range(1, 80));
      end
      cmp_code = ($urandom_range(0, 3) == 0) ? DW'($urandom) : start_val - DW'($urandom_range(0, 600));
      step(($urandom_range(0, 11) == 0));
    end

    // R10: random, filter on with varied window and threshold
    tag = "R10";
    filt_en = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      if (c % 200 == 0) begin
        start_val = DW'(200 + $urandom_range(0, 3800));
        step_val  = DW'($urandom_range(1, 80));
        filt_win  = WW'($urandom_range(1, (1 << WW) - 1));
        filt_thr  = WW'($urandom_range(1, LEN));
      end
      cmp_code = ($urandom_range(0, 3) == 0) ? DW'($urandom) : start_val - DW'($urandom_range(0, 600));
      step(($urandom_range(0, 11) == 0));
    end

    finish_run();
  end
endmodule